// File: doc/BRIEF.md
# Masked Packed Sign-Extension Unit

This block widens packed signed integers for a vector datapath whose widest register is 512 bits. It takes narrow elements from the bottom of a source vector and sign-extends each into a wider element of the destination. One operation is accepted per clock on a valid strobe, and the new destination value appears one clock later.

Six widening ratios and three vector lengths are supported. A per-element write mask decides which destination elements receive the widened value. Elements that the mask leaves out either keep their previous contents (merge) or are cleared (zero fill).

The destination bits above the active length are handled in one of two ways. A legacy mode keeps them as they were; the newer mode clears them. A 4-bit reserved field and a set of disallowed combinations are checked on every operation. An illegal operation raises a flag and returns the old destination unchanged. Instruction decode, memory operands and the register file sit outside this block.

Top module: `sext_widen_unit`

## Requirements
- R1: `cvt_sel` selects the conversion: 0 = 8→16, 1 = 8→32, 2 = 8→64, 3 = 16→32, 4 = 16→64, 5 = 32→64 bits. Each result element is the two's-complement sign extension of its source element.
- R2: Source elements are packed from bit 0 of `src` upward. Destination element j takes source element j, so a 512-bit 8→64 operation reads only `src[63:0]`.
- R3: `len_sel` selects the vector length: 0 = 128, 1 = 256, 2 = 512 bits. The active element count is the length divided by the result element width: 8/16/32 for 16-bit results, 4/8/16 for 32-bit results, 2/4/8 for 64-bit results.
- R4: An active element j receives its widened value when `mask_en` is 0 or `wmask[j]` is 1. Mask bits at or above the active element count have no effect on `dst_new`.
- R5: When `mask_en` is 1 and `wmask[j]` is 0, active element j keeps its `dst_old` value if `zero_fill` is 0, and becomes zero if `zero_fill` is 1.
- R6: When `legacy_mode` is 0, every `dst_new` bit from the vector length up to bit 511 is zero.
- R7: When `legacy_mode` is 1, the operation is 128 bits wide and unmasked, and `dst_new[511:128]` equals `dst_old[511:128]`.
- R8: If `rsvd_field` is not 4'b1111, `op_illegal` is 1 with the result, and `dst_new` equals `dst_old`.
- R9: The following are also illegal, with the same flag and the same unchanged result as R8:
  - `cvt_sel` of 6 or 7;
  - `len_sel` of 3;
  - `legacy_mode` of 1 together with `len_sel` not 0;
  - `legacy_mode` of 1 together with `mask_en` of 1.
- R10: `out_valid` is 1 exactly one clock after a cycle with `in_valid` at 1, and 0 otherwise. `op_illegal` is 0 whenever `out_valid` is 0. A synchronous reset clears `out_valid`, `op_illegal` and `dst_new`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation strobe; inputs are captured when high |
| src | input | 256 | Packed narrow source elements |
| dst_old | input | 512 | Current destination contents |
| wmask | input | 64 | Per-element write mask, bit j for element j |
| cvt_sel | input | 3 | Widening ratio code (R1) |
| len_sel | input | 2 | Vector length code (R3) |
| legacy_mode | input | 1 | 1 = keep upper destination bits, 128-bit unmasked only |
| mask_en | input | 1 | 1 = apply `wmask` |
| zero_fill | input | 1 | 1 = clear unselected elements, 0 = merge |
| rsvd_field | input | 4 | Reserved operand field, must be 4'b1111 |
| out_valid | output | 1 | Result valid, one clock after `in_valid` |
| dst_new | output | 512 | New destination value |
| op_illegal | output | 1 | Operation was illegal; `dst_new` holds `dst_old` |

## Verification
Within one result, masking and upper-bit handling act on the same destination bytes. A masked-off element near the length boundary must take merge or zero treatment, while the bytes just above it follow the length rule. The random stimulus produces both at once by drawing the mask, the policy, the length and the legacy flag independently. The result is judged against a bench model that builds every element bit by bit.

Reserved-field and combination errors are also mixed into the same stream. This confirms that an illegal operation overrides both the mask and the upper-bit rules and returns the old value.

// File: rtl/sxw_pkg.sv
package sxw_pkg;

  typedef enum logic [2:0] {
    CVT_B2W = 3'd0,
    CVT_B2D = 3'd1,
    CVT_B2Q = 3'd2,
    CVT_W2D = 3'd3,
    CVT_W2Q = 3'd4,
    CVT_D2Q = 3'd5
  } cvt_e;

  typedef enum logic [1:0] {
    LEN_BASE   = 2'd0,
    LEN_DOUBLE = 2'd1,
    LEN_QUAD   = 2'd2
  } len_e;

  localparam int NUM_CVT = 6;

  // narrow element width for a conversion index
  function automatic int cvt_src_bits(input int idx);
    case (idx)
      0, 1, 2: return 8;
      3, 4:    return 16;
      default: return 32;
    endcase
  endfunction

  // wide element width for a conversion index
  function automatic int cvt_dst_bits(input int idx);
    case (idx)
      0:       return 16;
      1, 3:    return 32;
      default: return 64;
    endcase
  endfunction

  // log2 of result element size in bytes
  function automatic logic [1:0] cvt_dst_shift(input logic [2:0] sel);
    case (sel)
      3'd0:       return 2'd1;
      3'd1, 3'd3: return 2'd2;
      default:    return 2'd3;
    endcase
  endfunction

  // legality of one operation
  function automatic logic op_is_bad(input logic [3:0] rsvd, input logic [2:0] sel,
                                     input logic [1:0] len, input logic legacy,
                                     input logic men);
    logic bad;
    bad = (rsvd != 4'b1111);
    bad = bad || (sel > 3'd5);
    bad = bad || (len == 2'd3);
    bad = bad || (legacy && ((len != 2'd0) || men));
    return bad;
  endfunction

endpackage

// File: rtl/sxw_widen.sv
module sxw_widen
  import sxw_pkg::*;
#(
  parameter int MAX_W = 512
) (
  input  logic [MAX_W/2-1:0] src,
  input  logic [2:0]         cvt_sel,
  output logic [MAX_W-1:0]   widened
);

  logic [NUM_CVT-1:0][MAX_W-1:0] per_cvt;

  for (genvar r = 0; r < NUM_CVT; r++) begin : g_cvt
    localparam int SW = cvt_src_bits(r);
    localparam int DW = cvt_dst_bits(r);
    localparam int NE = MAX_W / DW;
    for (genvar j = 0; j < NE; j++) begin : g_el
      assign per_cvt[r][j*DW +: DW] = {{(DW-SW){src[j*SW+SW-1]}}, src[j*SW +: SW]};
    end
  end

  always_comb begin
    widened = '0;
    for (int r = 0; r < NUM_CVT; r++) begin
      if (cvt_sel == 3'(r)) widened = per_cvt[r];
    end
  end

endmodule

// File: rtl/sxw_lane_ctl.sv
module sxw_lane_ctl #(
  parameter int MAX_W  = 512,
  parameter int MASK_W = 64
) (
  input  logic [2:0]          cvt_sel,
  input  logic [1:0]          len_eff,
  input  logic                mask_en,
  input  logic [MASK_W-1:0]   wmask,
  output logic [MAX_W/8-1:0]  in_range,
  output logic [MAX_W/8-1:0]  take_new
);

  localparam int BYTES      = MAX_W / 8;
  localparam int BW         = $clog2(BYTES) + 1;
  localparam int IDX_W      = $clog2(MASK_W);
  localparam int BASE_BYTES = BYTES / 4;

  logic [1:0]    shamt;
  logic [BW-1:0] vl_bytes;

  assign shamt    = sxw_pkg::cvt_dst_shift(cvt_sel);
  assign vl_bytes = BW'(BASE_BYTES) << len_eff;

  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    logic [IDX_W-1:0] elem_idx;
    assign elem_idx    = IDX_W'(b) >> shamt;
    assign in_range[b] = (BW'(b) < vl_bytes);
    assign take_new[b] = in_range[b] && (!mask_en || wmask[elem_idx]);
  end

endmodule

// File: rtl/sxw_merge.sv
module sxw_merge #(
  parameter int MAX_W = 512
) (
  input  logic [MAX_W-1:0]   widened,
  input  logic [MAX_W-1:0]   dst_old,
  input  logic [MAX_W/8-1:0] in_range,
  input  logic [MAX_W/8-1:0] take_new,
  input  logic               keep_upper,
  input  logic               zero_fill,
  input  logic               hold_all,
  output logic [MAX_W-1:0]   merged
);

  localparam int BYTES = MAX_W / 8;

  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    logic [7:0] old_b, new_b, pick;
    assign old_b = dst_old[b*8 +: 8];
    assign new_b = widened[b*8 +: 8];
    always_comb begin
      if (hold_all)          pick = old_b;
      else if (!in_range[b]) pick = keep_upper ? old_b : 8'h00;
      else if (take_new[b])  pick = new_b;
      else                   pick = zero_fill ? 8'h00 : old_b;
    end
    assign merged[b*8 +: 8] = pick;
  end

endmodule

// File: rtl/sext_widen_unit.sv
module sext_widen_unit
  import sxw_pkg::*;
#(
  parameter int MAX_W  = 512,
  parameter int MASK_W = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [MAX_W/2-1:0]  src,
  input  logic [MAX_W-1:0]    dst_old,
  input  logic [MASK_W-1:0]   wmask,
  input  logic [2:0]          cvt_sel,
  input  logic [1:0]          len_sel,
  input  logic                legacy_mode,
  input  logic                mask_en,
  input  logic                zero_fill,
  input  logic [3:0]          rsvd_field,
  output logic                out_valid,
  output logic [MAX_W-1:0]    dst_new,
  output logic                op_illegal
);

  localparam int BYTES = MAX_W / 8;

  // named internal events
  logic               op_bad;
  logic [1:0]         len_eff;
  logic [MAX_W-1:0]   widened;
  logic [BYTES-1:0]   in_range;
  logic [BYTES-1:0]   take_new;
  logic [MAX_W-1:0]   merged;

  assign op_bad  = op_is_bad(rsvd_field, cvt_sel, len_sel, legacy_mode, mask_en);
  assign len_eff = legacy_mode ? LEN_BASE : len_sel;

  sxw_widen #(.MAX_W(MAX_W)) u_widen (
    .src     (src),
    .cvt_sel (cvt_sel),
    .widened (widened)
  );

  sxw_lane_ctl #(.MAX_W(MAX_W), .MASK_W(MASK_W)) u_lane (
    .cvt_sel  (cvt_sel),
    .len_eff  (len_eff),
    .mask_en  (mask_en && !legacy_mode),
    .wmask    (wmask),
    .in_range (in_range),
    .take_new (take_new)
  );

  sxw_merge #(.MAX_W(MAX_W)) u_merge (
    .widened    (widened),
    .dst_old    (dst_old),
    .in_range   (in_range),
    .take_new   (take_new),
    .keep_upper (legacy_mode),
    .zero_fill  (zero_fill),
    .hold_all   (op_bad),
    .merged     (merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      op_illegal <= 1'b0;
      dst_new    <= '0;
    end else begin
      out_valid  <= in_valid;
      op_illegal <= in_valid && op_bad;
      if (in_valid) dst_new <= merged;
    end
  end

endmodule

// File: rtl/sxw_checker.sv
module sxw_checker #(
  parameter int MAX_W  = 512,
  parameter int MASK_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [MAX_W-1:0]  dst_old,
  input logic [MASK_W-1:0] wmask,
  input logic [1:0]        len_sel,
  input logic              legacy_mode,
  input logic              mask_en,
  input logic              zero_fill,
  input logic [3:0]        rsvd_field,
  input logic              op_bad,
  input logic              out_valid,
  input logic [MAX_W-1:0]  dst_new,
  input logic              op_illegal
);

  localparam int BASE_W = MAX_W / 4;

  p_latency_r10: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  p_flag_gated_r10: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> !op_illegal);

  p_reserved_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && rsvd_field != 4'b1111) |=> op_illegal);

  p_hold_on_bad_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_bad) |=> (dst_new == $past(dst_old)));

  p_legacy_mask_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && legacy_mode && mask_en) |=> op_illegal);

  p_upper_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !op_bad && !legacy_mode && len_sel == 2'd0)
      |=> (dst_new[MAX_W-1:BASE_W] == '0));

  p_legacy_upper_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !op_bad && legacy_mode)
      |=> (dst_new[MAX_W-1:BASE_W] == $past(dst_old[MAX_W-1:BASE_W])));

  p_zero_all_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !op_bad && mask_en && zero_fill && wmask == '0) |=> (dst_new == '0));

  p_merge_all_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !op_bad && mask_en && !zero_fill && wmask == '0 && len_sel == 2'd2)
      |=> (dst_new == $past(dst_old)));

endmodule

bind sext_widen_unit sxw_checker #(.MAX_W(MAX_W), .MASK_W(MASK_W)) u_sxw_checker (.*);

// File: tb/sext_widen_unit_bench.sv
module sext_widen_unit_bench;

  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [255:0] src;
  logic [511:0] dst_old;
  logic [63:0]  wmask;
  logic [2:0]   cvt_sel;
  logic [1:0]   len_sel;
  logic         legacy_mode, mask_en, zero_fill;
  logic [3:0]   rsvd_field;
  logic         out_valid, op_illegal;
  logic [511:0] dst_new;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #5 clk = ~clk;

  sext_widen_unit u_sext_widen_unit (.*);

  function automatic logic model_bad(input logic [3:0] rs, input logic [2:0] cs,
                                     input logic [1:0] ls, input logic lg, input logic me);
    if (rs != 4'hF) return 1'b1;
    if (cs == 3'd6 || cs == 3'd7) return 1'b1;
    if (ls == 2'd3) return 1'b1;
    if (lg && ls != 2'd0) return 1'b1;
    if (lg && me) return 1'b1;
    return 1'b0;
  endfunction

  // element-by-element, bit-by-bit reference
  function automatic logic [511:0] model(input logic [255:0] s, input logic [511:0] old,
                                         input logic [63:0] m, input logic [2:0] cs,
                                         input logic [1:0] ls, input logic lg,
                                         input logic me, input logic zf, input logic [3:0] rs);
    logic [511:0] r;
    int sw, dw, vl, ne;
    if (model_bad(rs, cs, ls, lg, me)) return old;
    sw = (cs <= 3'd2) ? 8 : (cs <= 3'd4) ? 16 : 32;
    dw = (cs == 3'd0) ? 16 : (cs == 3'd1 || cs == 3'd3) ? 32 : 64;
    vl = lg ? 128 : (128 * (1 << ls));
    ne = vl / dw;
    r  = lg ? old : '0;
    for (int j = 0; j < ne; j++) begin
      for (int k = 0; k < dw; k++) begin
        if (!me || m[j])
          r[j*dw+k] = (k < sw) ? s[j*sw+k] : s[j*sw+sw-1];
        else
          r[j*dw+k] = zf ? 1'b0 : old[j*dw+k];
      end
    end
    return r;
  endfunction

  function automatic logic [511:0] rnd512();
    logic [511:0] v;
    for (int i = 0; i < 16; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic check_bit(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic check_vec(input string tag, input logic [511:0] act, input logic [511:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_op(input string tag, input logic [255:0] s, input logic [511:0] old,
                        input logic [63:0] m, input logic [2:0] cs, input logic [1:0] ls,
                        input logic lg, input logic me, input logic zf, input logic [3:0] rs);
    logic [511:0] exp;
    logic         bad;
    src = s; dst_old = old; wmask = m; cvt_sel = cs; len_sel = ls;
    legacy_mode = lg; mask_en = me; zero_fill = zf; rsvd_field = rs;
    in_valid = 1'b1;
    exp = model(s, old, m, cs, ls, lg, me, zf, rs);
    bad = model_bad(rs, cs, ls, lg, me);
    @(negedge clk);
    check_bit({tag, " R10 valid"}, out_valid, 1'b1);
    check_bit({tag, " R8 R9 flag"}, op_illegal, bad);
    check_vec(tag, dst_new, exp);
  endtask

  task automatic idle_cycle();
    in_valid = 1'b0;
    dst_old  = rnd512();
    @(negedge clk);
    check_bit("R10 idle valid", out_valid, 1'b0);
    check_bit("R10 idle flag", op_illegal, 1'b0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [511:0] s, o;
    void'($urandom(32'h1357_9BDF));
    rst = 1'b1; in_valid = 1'b0; src = '0; dst_old = '0; wmask = '0;
    cvt_sel = '0; len_sel = '0; legacy_mode = 1'b0; mask_en = 1'b0;
    zero_fill = 1'b0; rsvd_field = 4'hF;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_bit("R10 reset valid", out_valid, 1'b0);
    check_bit("R10 reset flag", op_illegal, 1'b0);
    check_vec("R10 reset data", dst_new, '0);

    // R1: each ratio on negative and positive elements, 512-bit, unmasked
    for (int c = 0; c < 6; c++) begin
      s = rnd512(); o = rnd512();
      run_op("R1 ratio", s[255:0], o, '0, 3'(c), 2'd2, 1'b0, 1'b0, 1'b0, 4'hF);
    end
    // R2: 8->64 over 512 bits reads only the low 64 source bits
    o = rnd512();
    run_op("R2 low slice", {192'h0, 64'h7F80_01FF_8000_7FFF}, o, '0, 3'd2, 2'd2,
           1'b0, 1'b0, 1'b0, 4'hF);
    run_op("R2 high ignored", {192'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 64'h7F80_01FF_8000_7FFF},
           o, '0, 3'd2, 2'd2, 1'b0, 1'b0, 1'b0, 4'hF);
    // R3 R6: each length, upper bits cleared
    for (int l = 0; l < 3; l++) begin
      s = rnd512(); o = '1;
      run_op("R3 R6 length", s[255:0], o, '0, 3'd3, 2'(l), 1'b0, 1'b0, 1'b0, 4'hF);
    end
    // R4: mask bits above the active count are ignored (2 active elements)
    s = rnd512(); o = rnd512();
    run_op("R4 extra mask", s[255:0], o, 64'hFFFF_FFFF_FFFF_FFFC, 3'd5, 2'd0,
           1'b0, 1'b1, 1'b1, 4'hF);
    // R5: merge versus zero with alternating mask
    run_op("R5 merge", s[255:0], o, 64'hAAAA_AAAA_AAAA_AAAA, 3'd0, 2'd2, 1'b0, 1'b1, 1'b0, 4'hF);
    run_op("R5 zero", s[255:0], o, 64'hAAAA_AAAA_AAAA_AAAA, 3'd0, 2'd2, 1'b0, 1'b1, 1'b1, 4'hF);
    // R7: legacy mode keeps upper bits
    run_op("R7 legacy", s[255:0], o, 64'h0, 3'd1, 2'd0, 1'b1, 1'b0, 1'b0, 4'hF);
    // R8: reserved field
    run_op("R8 reserved", s[255:0], o, '1, 3'd0, 2'd2, 1'b0, 1'b0, 1'b0, 4'hE);
    run_op("R8 reserved zero", s[255:0], o, '1, 3'd4, 2'd1, 1'b0, 1'b1, 1'b1, 4'h0);
    // R9: disallowed combinations
    run_op("R9 legacy len", s[255:0], o, '1, 3'd0, 2'd1, 1'b1, 1'b0, 1'b0, 4'hF);
    run_op("R9 legacy mask", s[255:0], o, '1, 3'd0, 2'd0, 1'b1, 1'b1, 1'b0, 4'hF);
    run_op("R9 bad ratio", s[255:0], o, '1, 3'd6, 2'd0, 1'b0, 1'b0, 1'b0, 4'hF);
    run_op("R9 bad len", s[255:0], o, '1, 3'd2, 2'd3, 1'b0, 1'b0, 1'b0, 4'hF);
    idle_cycle();

    // random mix of all functions, occasional idle cycles
    for (int i = 0; i < 400; i++) begin
      logic [2:0] cs;
      logic [1:0] ls;
      logic lg, me;
      logic [3:0] rs;
      s  = rnd512(); o = rnd512();
      cs = 3'($urandom_range(0, 6));
      ls = 2'($urandom_range(0, 3));
      lg = ($urandom_range(0, 3) == 0);
      me = lg ? ($urandom_range(0, 7) == 0) : 1'($urandom);
      if (lg && $urandom_range(0, 3) != 0) ls = 2'd0;
      rs = ($urandom_range(0, 15) == 0) ? 4'($urandom) : 4'hF;
      run_op("R1 R2 R3 R4 R5 R6 R7 random", s[255:0], o,
             {$urandom, $urandom}, cs, ls, lg, me, 1'($urandom), rs);
      if ($urandom_range(0, 9) == 0) idle_cycle();
    end
    idle_cycle();

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule